// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog timer that software controls through a single 32-bit control and status register. The register is written with a one-cycle write strobe and read back through a read-data port that always shows the current register contents. The timeout is set by two independent 2-bit fields. One field picks the ratio of a clock prescaler. The other picks how many prescaled ticks make up one watchdog interval.

Expiry happens in two stages. When the interval runs out, an interrupt flag is set, and an interrupt line is driven if interrupts are enabled. A grace period of 1024 prescaled ticks then starts. If software has not restarted the count by the end of that period and reset generation is enabled, the block raises a system reset request for 16 core clocks and latches a reset flag. Software keeps the watchdog alive by writing the register back with the self-clearing restart bit set. Writing all zeros stops the watchdog.

Top module: `dogtimer`

## Requirements
- R1: After reset, `rd_data` reads 0, and `irq` and `sys_rst_req` are low.
- R2: Register fields read back as written:
  - bits [11:10] prescaler select
  - bit 7 run enable
  - bit 6 interrupt enable
  - bits [5:4] interval select
  - bit 1 reset enable

  Bit 0 (restart) always reads 0, and every bit not listed here reads 0.
- R3: Once enabled with a restart, the interrupt flag (bit 3) sets exactly BASE_TICKS·4^isel prescaled ticks after the restart write, where BASE_TICKS defaults to 4. `irq` is high only while both the flag and interrupt enable are set.
- R4: Prescaler select 00 divides the clock by 1. Selects 01, 10 and 11 divide by DIV_A, DIV_B and DIV_C, which default to 2, 16 and 512.
- R5: With reset enable set, `sys_rst_req` rises 1024 prescaled ticks after the interrupt flag sets and stays high for exactly 16 clocks. The reset flag (bit 2) sets on the same edge on which the request rises.
- R6: With reset enable clear, the grace period ends without any reset request, and the reset flag stays 0.
- R7: A write with bit 0 set clears the interval count and the prescaler on the next edge. Restart writes repeated more often than the interval keep the flag from ever setting, and the enable bit reads back 1 while the watchdog runs.
- R8: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 to a flag bit leaves that flag unchanged.
- R9: A write of all zeros stops the watchdog. After it, no flag sets and no reset request occurs.
- R10: If a restart write lands on the same edge on which the interval would expire, the restart wins. The flag stays clear and a new full interval starts.
- R11: A change to the interval select made without a restart takes effect on the next tick, using the count already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| irq | output | 1 | Pre-timeout interrupt |
| sys_rst_req | output | 1 | System reset request, 16 clocks long |

## Verification
Two events can fall in the same cycle: a restart write and the expiry of the interval. The bench provokes this by issuing the restart write exactly four cycles after a previous restart, at prescale 1 and interval select 0, so the restart lands on the edge on which the flag would otherwise set. The result is judged at the ports. The flag must be clear right after that edge and must stay clear for three more cycles. It must then set on the fourth cycle, which proves a new full interval started on the coincident edge.

// File: rtl/dogtimer_pkg.sv
package dogtimer_pkg;

  localparam int REG_W     = 32;
  localparam int HOLD_CLKS = 16;

  localparam int B_RESTART = 0;
  localparam int B_RST_EN  = 1;
  localparam int B_RST_FLG = 2;
  localparam int B_IRQ_FLG = 3;
  localparam int B_ISEL_LO = 4;
  localparam int B_IRQ_EN  = 6;
  localparam int B_RUN     = 7;
  localparam int B_DIV_LO  = 10;

  typedef struct packed {
    logic [1:0] div_sel;
    logic       run;
    logic       irq_en;
    logic [1:0] isel;
    logic       rst_en;
  } dog_ctl_t;

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_GRACE = 2'd1,
    ST_IDLE  = 2'd2
  } dog_stage_e;

endpackage

// File: rtl/dogtimer_prescale.sv
module dogtimer_prescale #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 16,
  parameter int DIV_C = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PW = $clog2(DIV_C + 1);

  logic [PW-1:0] pcnt_q, pcnt_n;
  logic [PW-1:0] ratio_m1;

  always_comb begin
    unique case (sel)
      2'b00:   ratio_m1 = '0;
      2'b01:   ratio_m1 = PW'(DIV_A - 1);
      2'b10:   ratio_m1 = PW'(DIV_B - 1);
      default: ratio_m1 = PW'(DIV_C - 1);
    endcase
  end

  assign tick = run && (pcnt_q >= ratio_m1);

  always_comb begin
    if (clr || !run || tick) pcnt_n = '0;
    else                     pcnt_n = pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_n;
  end

  // R4: prescaled ticks never come while stopped
  assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt_q == '0));

endmodule

// File: rtl/dogtimer_stages.sv
module dogtimer_stages
  import dogtimer_pkg::*;
#(
  parameter int BASE_TICKS  = 4,
  parameter int GRACE_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] isel,
  output logic       expire,
  output logic       fire
);
  localparam int CW = $clog2(BASE_TICKS * 64 + 1);
  localparam int GW = $clog2(GRACE_TICKS + 1);

  dog_stage_e    stage_q, stage_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [GW-1:0] gcnt_q, gcnt_n;
  logic [CW-1:0] limit_m1;
  logic          step;

  assign limit_m1 = (CW'(BASE_TICKS) << (2 * isel)) - CW'(1);
  assign step     = tick && !clr && run;
  assign expire   = step && (stage_q == ST_COUNT) && (cnt_q >= limit_m1);
  assign fire     = step && (stage_q == ST_GRACE) && (gcnt_q >= GW'(GRACE_TICKS - 1));

  always_comb begin
    stage_n = stage_q;
    cnt_n   = cnt_q;
    gcnt_n  = gcnt_q;
    if (clr || !run) begin
      stage_n = ST_COUNT;
      cnt_n   = '0;
      gcnt_n  = '0;
    end else if (expire) begin
      stage_n = ST_GRACE;
      cnt_n   = '0;
      gcnt_n  = '0;
    end else if (fire) begin
      stage_n = ST_IDLE;
      gcnt_n  = '0;
    end else if (step) begin
      if (stage_q == ST_COUNT) cnt_n  = cnt_q + CW'(1);
      if (stage_q == ST_GRACE) gcnt_n = gcnt_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_COUNT;
      cnt_q   <= '0;
      gcnt_q  <= '0;
    end else begin
      stage_q <= stage_n;
      cnt_q   <= cnt_n;
      gcnt_q  <= gcnt_n;
    end
  end

  // R5: the grace stage follows directly on an expiry
  assert_grace_after_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !clr) |=> (stage_q == ST_GRACE && gcnt_q == '0));

endmodule

// File: rtl/dogtimer_rstpulse.sv
module dogtimer_rstpulse
  import dogtimer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic req
);
  localparam int HW = $clog2(HOLD_CLKS + 1);

  logic [HW-1:0] hold_q, hold_n;

  always_comb begin
    if (start)              hold_n = HW'(HOLD_CLKS);
    else if (hold_q != '0)  hold_n = hold_q - HW'(1);
    else                    hold_n = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_n;
  end

  assign req = (hold_q != '0);

  // R5: the request lasts exactly sixteen clocks
  assert_hold_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(req, 16));

endmodule

// File: rtl/dogtimer.sv
module dogtimer
  import dogtimer_pkg::*;
#(
  parameter int DIV_A       = 2,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 512,
  parameter int BASE_TICKS  = 4,
  parameter int GRACE_TICKS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        sys_rst_req
);
  logic [1:0] rsync_q;
  logic       rst_i_n;
  dog_ctl_t   ctl_q, ctl_n;
  logic       irqf_q, irqf_n, rstf_q, rstf_n;
  logic       clr, tick, expire, fire, fire_rst;
  logic       unused_wr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  assign clr = wr_en && (wr_data[B_RESTART] || !wr_data[B_RUN]);
  assign fire_rst = fire && ctl_q.rst_en;

  always_comb begin
    ctl_n = ctl_q;
    if (wr_en) begin
      ctl_n.div_sel = wr_data[B_DIV_LO +: 2];
      ctl_n.run     = wr_data[B_RUN];
      ctl_n.irq_en  = wr_data[B_IRQ_EN];
      ctl_n.isel    = wr_data[B_ISEL_LO +: 2];
      ctl_n.rst_en  = wr_data[B_RST_EN];
    end
    irqf_n = (irqf_q && !(wr_en && wr_data[B_IRQ_FLG])) || expire;
    rstf_n = (rstf_q && !(wr_en && wr_data[B_RST_FLG])) || fire_rst;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctl_q  <= '0;
      irqf_q <= 1'b0;
      rstf_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      irqf_q <= irqf_n;
      rstf_q <= rstf_n;
    end
  end

  dogtimer_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .run(ctl_q.run), .clr(clr),
    .sel(ctl_q.div_sel), .tick(tick)
  );

  dogtimer_stages #(.BASE_TICKS(BASE_TICKS), .GRACE_TICKS(GRACE_TICKS)) u_stg (
    .clk(clk), .rst_n(rst_i_n), .run(ctl_q.run), .clr(clr), .tick(tick),
    .isel(ctl_q.isel), .expire(expire), .fire(fire)
  );

  dogtimer_rstpulse u_rst (
    .clk(clk), .rst_n(rst_i_n), .start(fire_rst), .req(sys_rst_req)
  );

  always_comb begin
    rd_data = '0;
    rd_data[B_DIV_LO +: 2]  = ctl_q.div_sel;
    rd_data[B_RUN]          = ctl_q.run;
    rd_data[B_IRQ_EN]       = ctl_q.irq_en;
    rd_data[B_ISEL_LO +: 2] = ctl_q.isel;
    rd_data[B_IRQ_FLG]      = irqf_q;
    rd_data[B_RST_FLG]      = rstf_q;
    rd_data[B_RST_EN]       = ctl_q.rst_en;
  end

  assign irq = irqf_q && ctl_q.irq_en;
  assign unused_wr_bits = ^{wr_data[31:12], wr_data[9:8]};

  // R5: reset flag is visible when the request starts
  assert_rst_flag_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(sys_rst_req) |-> rd_data[B_RST_FLG]);

  // R6: a request only starts when reset generation was enabled
  assert_rst_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(sys_rst_req) |-> $past(ctl_q.rst_en));

  // R9: a stopped watchdog never raises its interrupt flag
  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ctl_q.run |=> !$rose(irqf_q));

  // R10: a restart write beats a coincident expiry
  assert_restart_wins_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && wr_data[B_RESTART] && !irqf_q) |=> !irqf_q);

endmodule

// File: tb/dogtimer_test.sv
`timescale 1ns/1ps
module dogtimer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, sys_rst_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  dogtimer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // stimulus table: prescaler select, interval select, expected cycles (R3, R4)
  localparam int NV = 9;
  localparam int VDIV[NV] = '{0, 0, 0, 0, 1, 1, 2, 2, 3};
  localparam int VIS [NV] = '{0, 1, 2, 3, 0, 1, 0, 1, 0};
  localparam int VCYC[NV] = '{4, 16, 64, 256, 8, 32, 64, 256, 2048};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 sys_rst_req", {31'b0, sys_rst_req}, 32'h0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 rd_data after release", rd_data, 32'h0);

    // R2 readback, restart bit and unused bits read zero
    wr(32'h8000_0C73);
    chk("R2 readback", rd_data, 32'h0000_0C72);
    wr(32'h0);

    // R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      wr(32'h41 | 32'h80 | (32'(VDIV[i]) << 10) | (32'(VIS[i]) << 4));
      idle(VCYC[i] - 1);
      chk($sformatf("R3 R4 v%0d flag early", i), {31'b0, rd_data[3]}, 32'h0);
      idle(1);
      chk($sformatf("R3 R4 v%0d flag", i), {31'b0, rd_data[3]}, 32'h1);
      chk($sformatf("R3 v%0d irq", i), {31'b0, irq}, 32'h1);
      wr(32'h8);
      chk($sformatf("R8 v%0d clear", i), rd_data, 32'h0);
    end

    // R5 grace period and reset pulse
    wr(32'h83);
    idle(1027);
    chk("R5 no req early", {31'b0, sys_rst_req}, 32'h0);
    chk("R5 flag early", {31'b0, rd_data[2]}, 32'h0);
    idle(1);
    chk("R5 req", {31'b0, sys_rst_req}, 32'h1);
    chk("R5 flags", rd_data, 32'h8E);
    idle(15);
    chk("R5 req held", {31'b0, sys_rst_req}, 32'h1);
    idle(1);
    chk("R5 req ends", {31'b0, sys_rst_req}, 32'h0);

    // R8 write-one-to-clear
    wr(32'h82);
    chk("R8 zero keeps flags", rd_data, 32'h8E);
    wr(32'h8A);
    chk("R8 clear irq flag", rd_data, 32'h86);
    wr(32'h86);
    chk("R8 clear rst flag", rd_data, 32'h82);
    wr(32'h0);

    // R6 no reset without reset enable; R3 irq masked
    begin
      int seen = 0;
      wr(32'h81);
      for (int k = 0; k < 1100; k++) begin
        idle(1);
        if (sys_rst_req) seen = 1;
      end
      chk("R6 no request", 32'(seen), 32'h0);
      chk("R6 flags", rd_data, 32'h88);
      chk("R3 irq masked", {31'b0, irq}, 32'h0);
      wr(32'h8);
    end

    // R7 keep-alive
    wr(32'h81);
    for (int k = 0; k < 10; k++) begin
      idle(2);
      wr(32'h81);
    end
    chk("R7 no flag", {31'b0, rd_data[3]}, 32'h0);
    chk("R7 running", {31'b0, rd_data[7]}, 32'h1);
    idle(3);
    chk("R7 still no flag", {31'b0, rd_data[3]}, 32'h0);
    idle(1);
    chk("R7 flag after last", {31'b0, rd_data[3]}, 32'h1);
    wr(32'h8);

    // R9 stop
    wr(32'h83);
    idle(2);
    wr(32'h0);
    idle(1100);
    chk("R9 stopped", rd_data, 32'h0);
    chk("R9 no req", {31'b0, sys_rst_req}, 32'h0);

    // R10 restart coincident with expiry
    wr(32'h81);
    idle(3);
    wr(32'h81);
    chk("R10 restart wins", {31'b0, rd_data[3]}, 32'h0);
    idle(3);
    chk("R10 new interval", {31'b0, rd_data[3]}, 32'h0);
    idle(1);
    chk("R10 expiry", {31'b0, rd_data[3]}, 32'h1);
    wr(32'h8);

    // R11 live interval change
    wr(32'hB1);
    idle(10);
    wr(32'h80);
    chk("R11 not yet", {31'b0, rd_data[3]}, 32'h0);
    idle(1);
    chk("R11 immediate", {31'b0, rd_data[3]}, 32'h1);
    wr(32'h99);
    idle(15);
    chk("R11 new timeout early", {31'b0, rd_data[3]}, 32'h0);
    idle(1);
    chk("R11 new timeout", {31'b0, rd_data[3]}, 32'h1);
    wr(32'h8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule